// File: doc/BRIEF.md
# Flash Program/Erase Status Register

This block holds the 8-bit status byte of a NOR-style flash command interface and decides what a bus read returns. Its inputs are the run state of the internal program/erase controller, the failure strobes that the controller raises after its last pulse, the supply check taken when an operation is requested, and the decoded suspend, resume and clear commands. The byte reports whether the controller is ready and whether a suspend is pending or in effect. It also carries three sticky error flags. While any of those flags is set, no new operation is allowed to start.

A separate read path captures the byte when a read begins, which is when either chip-enable or output-enable falls. It holds that snapshot until the same enable goes high again. A host that polls must therefore toggle an enable to see a fresh value. The block also drives a select that steers the read-data multiplexer to the status byte. It does this whenever the controller is running or the command decoder is in status-read mode.

Top module: `flash_status_reg`

## Requirements
- R1: Bit 7 of `status_live` is 1 on the cycle after `pec_running` was low and 0 on the cycle after it was high. After a suspend it stays 0 until the controller stops running.
- R2: After reset, `status_live` and `bus_status` read 0x80 and `op_go` and `rd_sel_status` read 0. Bits 1 and 0 of the status byte are always 0.
- R3: `cmd_suspend` while `pec_running` is high and no suspend bit is set sets bit 6 (erase) or bit 2 (program) on the next cycle. The choice follows the kind of the last accepted operation. A suspend while idle is ignored. `cmd_resume` clears both bits.
- R4: `pec_done` clears both suspend bits on the next cycle, so an operation that completes before pausing ends as a normal completion.
- R5: `erase_fail` sets bit 5 and `prog_fail` sets bit 4 on the next cycle.
- R6: `op_start` with `supply_ok` low sets bit 3, and that operation is not started (`op_go` stays 0).
- R7: Bits 5, 4 and 3 stay set until `cmd_clear` or reset. A set event in the same cycle as `cmd_clear` wins.
- R8: `op_go` pulses for one cycle, one cycle after `op_start`, only if `supply_ok` was high and bits 5..3 were all 0.
- R9: `rd_sel_status` equals `status_mode | pec_running` delayed by one cycle.
- R10: When no snapshot is held and an enable falls, `bus_status` takes the status value of that same edge. The enable that fell owns the snapshot; if both fall together, chip-enable owns it. The value is held until the owning enable rises, and falls of the other enable are ignored in the meantime.
- R11: After the snapshot is released, `bus_status` does not change until a new falling edge occurs, even if an enable is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pec_running | input | 1 | Controller is executing an operation (low when idle or paused) |
| pec_done | input | 1 | Controller finished an operation (strobe) |
| op_start | input | 1 | Decoded program or erase request (strobe) |
| op_is_erase | input | 1 | Kind of the request: 1 erase, 0 program |
| supply_ok | input | 1 | Programming supply at or above the lockout level |
| prog_fail | input | 1 | Program pulses exhausted without verify (strobe) |
| erase_fail | input | 1 | Erase pulses exhausted without verify (strobe) |
| cmd_suspend | input | 1 | Decoded suspend command |
| cmd_resume | input | 1 | Decoded resume command |
| cmd_clear | input | 1 | Decoded clear-status command |
| status_mode | input | 1 | Decoder is in status-read mode |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| op_go | output | 1 | Accepted operation, start the controller |
| rd_sel_status | output | 1 | Read mux selects the status byte |
| status_live | output | 8 | Current status byte |
| bus_status | output | 8 | Status snapshot presented on reads |

## Verification
On every cycle the assertions check the following: the ready bit follows the controller's run state, the reserved bits are 0, the two suspend bits are never set together, and no error flag drops without a clear. They also check that a start grant requires a clean request, that the read select lags its inputs by one cycle, and that the snapshot is stable while both enables stay low. Other properties depend on an order of events, and only the bench scenarios can show them. These are which suspend bit an accepted erase or program selects, completion overriding a pending suspend, set-wins-over-clear, ownership of the snapshot by the enable that fell first, and the need for a fresh edge after release.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned SR_W     = 8;
  localparam int unsigned B_READY  = 7;
  localparam int unsigned B_ESUS   = 6;
  localparam int unsigned B_EFAIL  = 5;
  localparam int unsigned B_PFAIL  = 4;
  localparam int unsigned B_SUPPLY = 3;
  localparam int unsigned B_PSUS   = 2;
  localparam int unsigned RSV_W    = 2;
  localparam logic [SR_W-1:0] SR_RESET = 8'h80;

  typedef enum logic {OWN_CE = 1'b0, OWN_OE = 1'b1} latch_owner_e;
endpackage

// File: rtl/fsr_status_core.sv
module fsr_status_core
  import fsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pec_running,
  input  logic            pec_done,
  input  logic            op_start,
  input  logic            op_is_erase,
  input  logic            supply_ok,
  input  logic            prog_fail,
  input  logic            erase_fail,
  input  logic            cmd_suspend,
  input  logic            cmd_resume,
  input  logic            cmd_clear,
  output logic [SR_W-1:0] status_q,
  output logic            go_q
);
  logic ready_q, esus_q, psus_q, efail_q, pfail_q, supply_q, kind_q;
  logic err_any, accept, susp_ok;

  assign err_any = efail_q | pfail_q | supply_q;
  assign accept  = op_start & supply_ok & ~err_any;
  assign susp_ok = cmd_suspend & pec_running & ~esus_q & ~psus_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= 1'b1;
      esus_q   <= 1'b0;
      psus_q   <= 1'b0;
      efail_q  <= 1'b0;
      pfail_q  <= 1'b0;
      supply_q <= 1'b0;
      kind_q   <= 1'b0;
      go_q     <= 1'b0;
    end else begin
      ready_q <= ~pec_running;
      go_q    <= accept;
      if (accept) kind_q <= op_is_erase;

      if (erase_fail)     efail_q <= 1'b1;
      else if (cmd_clear) efail_q <= 1'b0;

      if (prog_fail)      pfail_q <= 1'b1;
      else if (cmd_clear) pfail_q <= 1'b0;

      if (op_start && !supply_ok) supply_q <= 1'b1;
      else if (cmd_clear)         supply_q <= 1'b0;

      if (pec_done || cmd_resume) begin
        esus_q <= 1'b0;
        psus_q <= 1'b0;
      end else if (susp_ok) begin
        if (kind_q) esus_q <= 1'b1;
        else        psus_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_q           = '0;
    status_q[B_READY]  = ready_q;
    status_q[B_ESUS]   = esus_q;
    status_q[B_EFAIL]  = efail_q;
    status_q[B_PFAIL]  = pfail_q;
    status_q[B_SUPPLY] = supply_q;
    status_q[B_PSUS]   = psus_q;
  end
endmodule

// File: rtl/fsr_read_latch.sv
module fsr_read_latch
  import fsr_pkg::*;
#(
  parameter int unsigned W = SR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic [W-1:0] live,
  output logic [W-1:0] bus_q
);
  logic         ce_d, oe_d, held_q;
  latch_owner_e own_q;
  logic         ce_fall, oe_fall, owner_up;

  assign ce_fall  = ce_d & ~ce_n;
  assign oe_fall  = oe_d & ~oe_n;
  assign owner_up = (own_q == OWN_CE) ? ce_n : oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_d   <= 1'b1;
      oe_d   <= 1'b1;
      held_q <= 1'b0;
      own_q  <= OWN_CE;
      bus_q  <= W'(SR_RESET);
    end else begin
      ce_d <= ce_n;
      oe_d <= oe_n;
      if (!held_q) begin
        if (ce_fall || oe_fall) begin
          held_q <= 1'b1;
          own_q  <= ce_fall ? OWN_CE : OWN_OE;
          bus_q  <= live;
        end
      end else if (owner_up) begin
        held_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsr_read_route.sv
module fsr_read_route (
  input  logic clk,
  input  logic rst,
  input  logic status_mode,
  input  logic pec_running,
  output logic sel_q
);
  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= status_mode | pec_running;
  end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pec_running,
  input  logic            pec_done,
  input  logic            op_start,
  input  logic            op_is_erase,
  input  logic            supply_ok,
  input  logic            prog_fail,
  input  logic            erase_fail,
  input  logic            cmd_suspend,
  input  logic            cmd_resume,
  input  logic            cmd_clear,
  input  logic            status_mode,
  input  logic            ce_n,
  input  logic            oe_n,
  output logic            op_go,
  output logic            rd_sel_status,
  output logic [SR_W-1:0] status_live,
  output logic [SR_W-1:0] bus_status
);
  fsr_status_core u_core (
    .clk(clk), .rst(rst), .pec_running(pec_running), .pec_done(pec_done),
    .op_start(op_start), .op_is_erase(op_is_erase), .supply_ok(supply_ok),
    .prog_fail(prog_fail), .erase_fail(erase_fail), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_clear(cmd_clear),
    .status_q(status_live), .go_q(op_go)
  );

  fsr_read_latch #(.W(SR_W)) u_latch (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n),
    .live(status_live), .bus_q(bus_status)
  );

  fsr_read_route u_route (
    .clk(clk), .rst(rst), .status_mode(status_mode),
    .pec_running(pec_running), .sel_q(rd_sel_status)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic       clk,
  input logic       rst,
  input logic       pec_running,
  input logic       pec_done,
  input logic       op_start,
  input logic       supply_ok,
  input logic       cmd_clear,
  input logic       status_mode,
  input logic       ce_n,
  input logic       oe_n,
  input logic       op_go,
  input logic       rd_sel_status,
  input logic [7:0] status_live,
  input logic [7:0] bus_status
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> status_live[7] == !$past(pec_running));

  assert_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    status_live[1:0] == 2'b00);

  assert_one_suspend_R3: assert property (@(posedge clk) disable iff (rst)
    !(status_live[6] && status_live[2]));

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(pec_done) |-> !status_live[6] && !status_live[2]);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(cmd_clear) |->
      (($past(status_live[5:3]) & ~status_live[5:3]) == 3'b000));

  assert_go_clean_R8: assert property (@(posedge clk) disable iff (rst)
    op_go |-> $past(op_start) && $past(supply_ok) && ($past(status_live[5:3]) == 3'b000));

  assert_select_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> rd_sel_status == $past(status_mode || pec_running));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(!rst, 2) && !$past(ce_n) && !$past(oe_n) &&
    !$past(ce_n, 2) && !$past(oe_n, 2) |-> $stable(bus_status));
endmodule

bind flash_status_reg fsr_checker u_chk (
  .clk(clk), .rst(rst), .pec_running(pec_running), .pec_done(pec_done),
  .op_start(op_start), .supply_ok(supply_ok), .cmd_clear(cmd_clear),
  .status_mode(status_mode), .ce_n(ce_n), .oe_n(oe_n), .op_go(op_go),
  .rd_sel_status(rd_sel_status), .status_live(status_live), .bus_status(bus_status)
);

// File: tb/flash_status_reg_bench.sv
`timescale 1ns/1ps
module flash_status_reg_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pec_running = 0, pec_done = 0, op_start = 0, op_is_erase = 0, supply_ok = 1;
  logic prog_fail = 0, erase_fail = 0, cmd_suspend = 0, cmd_resume = 0, cmd_clear = 0;
  logic status_mode = 0, ce_n = 1, oe_n = 1;
  logic op_go, rd_sel_status;
  logic [7:0] status_live, bus_status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_status_reg u_flash_status_reg (
    .clk(clk), .rst(rst), .pec_running(pec_running), .pec_done(pec_done),
    .op_start(op_start), .op_is_erase(op_is_erase), .supply_ok(supply_ok),
    .prog_fail(prog_fail), .erase_fail(erase_fail), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_clear(cmd_clear), .status_mode(status_mode),
    .ce_n(ce_n), .oe_n(oe_n), .op_go(op_go), .rd_sel_status(rd_sel_status),
    .status_live(status_live), .bus_status(bus_status)
  );

  // behavioural reference model
  int m_ready, m_esus, m_psus, m_efail, m_pfail, m_sup, m_kind, m_go, m_sel;
  int m_held, m_owner_oe, m_ce_prev, m_oe_prev;
  int m_bus;

  function automatic int m_status();
    return m_ready*128 + m_esus*64 + m_efail*32 + m_pfail*16 + m_sup*8 + m_psus*4;
  endfunction

  always @(posedge clk) begin
    int live_now, err, go, nfall_ce, nfall_oe;
    if (rst) begin
      m_ready = 1; m_esus = 0; m_psus = 0; m_efail = 0; m_pfail = 0; m_sup = 0;
      m_kind = 0; m_go = 0; m_sel = 0; m_held = 0; m_owner_oe = 0;
      m_ce_prev = 1; m_oe_prev = 1; m_bus = 128;
    end else begin
      live_now = m_status();
      nfall_ce = (m_ce_prev == 1 && ce_n == 0);
      nfall_oe = (m_oe_prev == 1 && oe_n == 0);
      if (m_held == 0) begin
        if (nfall_ce || nfall_oe) begin
          m_held = 1; m_owner_oe = nfall_ce ? 0 : 1; m_bus = live_now;
        end
      end else if ((m_owner_oe == 0 && ce_n) || (m_owner_oe == 1 && oe_n)) m_held = 0;
      m_ce_prev = ce_n; m_oe_prev = oe_n;
      err = m_efail + m_pfail + m_sup;
      go = (op_start && supply_ok && err == 0);
      if (pec_done || cmd_resume) begin m_esus = 0; m_psus = 0; end
      else if (cmd_suspend && pec_running && m_esus == 0 && m_psus == 0) begin
        if (m_kind) m_esus = 1; else m_psus = 1;
      end
      if (erase_fail) m_efail = 1; else if (cmd_clear) m_efail = 0;
      if (prog_fail) m_pfail = 1; else if (cmd_clear) m_pfail = 0;
      if (op_start && !supply_ok) m_sup = 1; else if (cmd_clear) m_sup = 0;
      if (go) m_kind = op_is_erase;
      m_go = go;
      m_ready = pec_running ? 0 : 1;
      m_sel = (status_mode || pec_running);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(status_live[7] == m_ready[0], "R1 ready bit", status_live[7], m_ready);
      check(status_live[1:0] == 2'b00, "R2 reserved bits", status_live[1:0], 0);
      check({status_live[6], status_live[2]} == {m_esus[0], m_psus[0]}, "R3/R4 suspend bits",
            {status_live[6], status_live[2]}, m_esus*2 + m_psus);
      check(status_live[5:4] == {m_efail[0], m_pfail[0]}, "R5/R7 fail bits",
            status_live[5:4], m_efail*2 + m_pfail);
      check(status_live[3] == m_sup[0], "R6/R7 supply bit", status_live[3], m_sup);
      check(op_go == m_go[0], "R8 op_go", op_go, m_go);
      check(rd_sel_status == m_sel[0], "R9 read select", rd_sel_status, m_sel);
      check(bus_status == m_bus[7:0], "R10/R11 bus snapshot", bus_status, m_bus);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick();
    check(status_live == 8'h80, "R2 reset status", status_live, 8'h80);
    check(bus_status == 8'h80 && !op_go && !rd_sel_status, "R2 reset outputs", bus_status, 8'h80);

    // accepted program, then suspend and pause
    op_start = 1; op_is_erase = 0; supply_ok = 1; tick();
    op_start = 0;
    check(op_go == 1'b1, "R8 clean start granted", op_go, 1);
    pec_running = 1; tick(2);
    check(status_live == 8'h00, "R1 busy reads 0x00", status_live, 8'h00);
    check(rd_sel_status == 1'b1, "R9 select while running", rd_sel_status, 1);
    cmd_suspend = 1; tick(); cmd_suspend = 0;
    check(status_live == 8'h04, "R3 program suspend pending, R1 still busy", status_live, 8'h04);
    pec_running = 0; tick(2);
    check(status_live == 8'h84, "R1 ready after pause", status_live, 8'h84);
    cmd_suspend = 1; tick(); cmd_suspend = 0;
    check(status_live == 8'h84, "R3 suspend while idle ignored", status_live, 8'h84);

    // read snapshots
    oe_n = 0; tick();
    check(bus_status == 8'h84, "R10 capture on oe fall", bus_status, 8'h84);
    cmd_resume = 1; pec_running = 1; tick(); cmd_resume = 0; tick();
    check(status_live == 8'h00, "R3 resume clears suspend", status_live, 8'h00);
    check(bus_status == 8'h84, "R10 held while oe low", bus_status, 8'h84);
    ce_n = 0; tick(); ce_n = 1; tick();
    check(bus_status == 8'h84, "R10 other enable ignored", bus_status, 8'h84);
    oe_n = 1; tick(); oe_n = 0; tick();
    check(bus_status == 8'h00, "R10 fresh capture after toggle", bus_status, 8'h00);
    oe_n = 1;
    pec_running = 0; pec_done = 1; tick(); pec_done = 0; tick();
    check(status_live == 8'h80, "R1 completion", status_live, 8'h80);

    // erase: suspend then completion before pause
    op_start = 1; op_is_erase = 1; tick(); op_start = 0;
    pec_running = 1; tick();
    cmd_suspend = 1; tick(); cmd_suspend = 0;
    check(status_live == 8'h40, "R3 erase suspend pending", status_live, 8'h40);
    pec_done = 1; pec_running = 0; tick(); pec_done = 0; tick();
    check(status_live == 8'h80, "R4 completion beats suspend", status_live, 8'h80);

    // failures and sticky behaviour
    erase_fail = 1; tick(); erase_fail = 0;
    check(status_live == 8'hA0, "R5 erase failure", status_live, 8'hA0);
    op_start = 1; op_is_erase = 0; tick(); op_start = 0;
    check(op_go == 1'b0, "R8 start blocked by error", op_go, 0);
    tick();
    check(status_live == 8'hA0, "R7 error stays set", status_live, 8'hA0);
    prog_fail = 1; tick(); prog_fail = 0;
    check(status_live == 8'hB0, "R5 program failure", status_live, 8'hB0);
    cmd_clear = 1; erase_fail = 1; tick(); cmd_clear = 0; erase_fail = 0;
    check(status_live == 8'hA0, "R7 set wins over clear", status_live, 8'hA0);
    cmd_clear = 1; tick(); cmd_clear = 0;
    check(status_live == 8'h80, "R7 clear", status_live, 8'h80);

    // supply low
    op_start = 1; supply_ok = 0; tick(); op_start = 0; supply_ok = 1;
    check(op_go == 1'b0 && status_live == 8'h88, "R6 supply lockout", status_live, 8'h88);
    cmd_clear = 1; tick(); cmd_clear = 0;
    check(status_live == 8'h80, "R7 supply bit cleared", status_live, 8'h80);
    status_mode = 1; tick(); status_mode = 0;
    check(rd_sel_status == 1'b1, "R9 select in status mode", rd_sel_status, 1);

    // both enables fall together: chip enable owns the snapshot
    ce_n = 0; oe_n = 0; tick();
    check(bus_status == 8'h80, "R10 joint capture", bus_status, 8'h80);
    oe_n = 1; pec_running = 1; tick(3);
    oe_n = 0; tick();
    check(bus_status == 8'h80, "R10 chip enable still owns", bus_status, 8'h80);
    ce_n = 1; tick(2);
    check(bus_status == 8'h80, "R11 no capture without new fall", bus_status, 8'h80);
    ce_n = 0; tick();
    check(bus_status == 8'h00, "R11 new fall captures", bus_status, 8'h00);
    ce_n = 1; oe_n = 1; pec_running = 0; tick(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule